// File: doc/BRIEF.md
# Perspective Divide Unit with Newton-Refined Reciprocal

This block takes one vertex at a time (x, y, z and a positive homogeneous weight w) and returns the projected coordinates x/w, y/w and z/w. It never divides. It computes the reciprocal of w once and then multiplies each of the three coordinates by it. To get the reciprocal it first normalizes w by its leading-zero count into a mantissa in [1,2). The top mantissa fraction bits then index a small seed table. Two Newton steps r' = r·(2 − m·r) refine the seed, and the result is shifted back by the same leading-zero count before the coordinate products.

All numbers are fixed point. The coordinates and the results are signed with W_FRAC fraction bits, and w is unsigned with W_FRAC fraction bits. With the defaults that means signed Q8.8 in and out and unsigned Q8.8 for w. One multiplier is shared across every step, and a state machine sequences it:

- IDLE accepts the vertex and goes to NORM.
- NORM loads the mantissa, the shift and the seed, then goes to EST1. If w is zero it goes straight to DONE.
- The Newton steps run EST1 → REF1 → EST2 → REF2.
- The coordinate products run MULX → MULY → MULZ → DONE.
- DONE presents the result for one cycle and returns to IDLE.

Top module: `persp_div_unit`

## Requirements
- R1: After reset, out_valid and out_err are 0 and in_ready is 1. No result appears before a vertex has been accepted.
- R2: A vertex is taken on a clock edge where in_valid and in_ready are both 1. From the next cycle until the result cycle has ended, in_ready is 0, and any vertex offered in that time is ignored. in_ready is 1 again in the cycle after the result cycle.
- R3: For every nonzero w, each output is within 2 LSB of the exact quotient coordinate·2^W_FRAC / w. The quotient is first clamped to the signed C_W-bit range.
- R4: A quotient above the largest signed C_W-bit value gives exactly 32767 (default width). A quotient below the smallest gives exactly −32768.
- R5: A w of zero sets out_err to 1 in the result cycle. All three outputs are then 32767, and the result cycle is the second cycle after acceptance.
- R6: For a nonzero w, out_valid rises in the ninth cycle after acceptance and stays high for exactly one cycle.
- R7: out_err is 1 only in a result cycle whose vertex had w equal to zero. For every nonzero w it is 0.
- R8: The reciprocal is accurate across the whole input range of w, from the smallest code 1 to the largest code 65535 and at every power of two. R3 holds at each of these values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Vertex offered |
| in_ready | output | 1 | Unit idle, vertex will be taken |
| in_x | input | C_W | Signed x coordinate |
| in_y | input | C_W | Signed y coordinate |
| in_z | input | C_W | Signed z coordinate |
| in_w | input | W_W | Unsigned weight w |
| out_valid | output | 1 | One-cycle result strobe |
| out_x | output | C_W | Projected x |
| out_y | output | C_W | Projected y |
| out_z | output | C_W | Projected z |
| out_err | output | 1 | w was zero; outputs saturated |

## Verification
The bench sweeps w over every power of two and the smallest and largest codes. These are the places where a wrong leading-zero count or a wrong back-shift would be off by a factor of two, and where a seed index taken from the wrong mantissa bits would miss the 2 LSB bound badly. Large coordinates over tiny w drive the clamp both ways, where a missing clamp would wrap to the opposite sign. A w of zero must take the short path with the error flag, not run the iterations on a garbage mantissa. While the unit is busy the bench keeps offering a different vertex with w equal to zero. A design that leaked ready or latched that vertex would return the wrong values or a spurious error.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_NORM,
        ST_EST1,
        ST_REF1,
        ST_EST2,
        ST_REF2,
        ST_MULX,
        ST_MULY,
        ST_MULZ,
        ST_DONE
    } pd_state_e;

    // cycles from acceptance edge to the result cycle
    localparam int PD_LAT_NZ   = 9;
    localparam int PD_LAT_ZERO = 2;

    // Seed for mantissa interval i: 1/m evaluated at the interval midpoint,
    // scaled by 2^seed_w and rounded to nearest.
    function automatic int seed_calc(int i, int idx_w, int seed_w);
        int num;
        int den;
        num = 1 << (seed_w + idx_w + 1);
        den = (1 << (idx_w + 1)) + 2 * i + 1;
        return (num + den / 2) / den;
    endfunction

endpackage

// File: rtl/pd_lzc_norm.sv
module pd_lzc_norm #(
    parameter int W_W  = 16,
    parameter int LZ_W = $clog2(W_W)
) (
    input  logic [W_W-1:0]  w,
    output logic [LZ_W-1:0] lz,
    output logic [W_W-1:0]  mant,
    output logic            is_zero
);

    logic found;

    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = W_W - 1; i >= 0; i--) begin
            if (!found && w[i]) begin
                lz    = LZ_W'(W_W - 1 - i);
                found = 1'b1;
            end
        end
        is_zero = !found;
        mant    = w << lz;
    end

endmodule

// File: rtl/pd_seed_rom.sv
module pd_seed_rom #(
    parameter int IDX_W  = 6,
    parameter int SEED_W = 10
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [SEED_W-1:0] seed
);

    localparam int DEPTH = 1 << IDX_W;

    logic [SEED_W-1:0] tbl [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign tbl[g] = SEED_W'(pdiv_pkg::seed_calc(g, IDX_W, SEED_W));
    end

    assign seed = tbl[idx];

endmodule

// File: rtl/pd_mul.sv
module pd_mul #(
    parameter int AW = 24,
    parameter int BW = 38,
    parameter int PW = AW + BW + 1
) (
    input  logic signed [AW-1:0] a,
    input  logic        [BW-1:0] b,
    output logic signed [PW-1:0] p
);

    logic signed [BW:0]   b_s;
    logic signed [PW-1:0] a_x;
    logic signed [PW-1:0] b_x;

    assign b_s = $signed({1'b0, b});
    assign a_x = PW'(a);
    assign b_x = PW'(b_s);
    assign p   = a_x * b_x;

endmodule

// File: rtl/persp_div_unit.sv
module persp_div_unit #(
    parameter int C_W    = 16,
    parameter int W_W    = 16,
    parameter int W_FRAC = 8,
    parameter int IDX_W  = 6,
    parameter int SEED_W = 10,
    parameter int MF     = 22
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic signed [C_W-1:0] in_x,
    input  logic signed [C_W-1:0] in_y,
    input  logic signed [C_W-1:0] in_z,
    input  logic [W_W-1:0]        in_w,
    output logic                  out_valid,
    output logic signed [C_W-1:0] out_x,
    output logic signed [C_W-1:0] out_y,
    output logic signed [C_W-1:0] out_z,
    output logic                  out_err
);
    import pdiv_pkg::*;

    localparam int LZ_W   = $clog2(W_W);
    localparam int RB     = MF + 1;
    localparam int EB     = RB + 1;
    localparam int AW0    = (C_W > EB) ? C_W : EB;
    localparam int AW     = (AW0 > W_W + 1) ? AW0 : W_W + 1;
    localparam int BW     = RB + W_W - 1;
    localparam int PW     = AW + BW + 1;
    localparam int SH     = MF + W_W - 1 - W_FRAC;
    localparam int SEED_S = MF - SEED_W;
    localparam logic signed [C_W-1:0] SAT_HI = {1'b0, {(C_W-1){1'b1}}};
    localparam logic signed [C_W-1:0] SAT_LO = {1'b1, {(C_W-1){1'b0}}};

    pd_state_e state_q, state_d;

    logic signed [C_W-1:0] x_q, y_q, z_q;
    logic [W_W-1:0]        w_q;
    logic [W_W-1:0]        m_q;
    logic [LZ_W-1:0]       lz_q;
    logic [RB-1:0]         r_q;
    logic [EB-1:0]         e_q;
    logic                  err_q;
    logic signed [C_W-1:0] ox_q, oy_q, oz_q;

    logic [LZ_W-1:0]       lz_c;
    logic [W_W-1:0]        mant_c;
    logic                  zero_c;
    logic [SEED_W-1:0]     seed_c;
    logic signed [AW-1:0]  mul_a;
    logic [BW-1:0]         mul_b;
    logic signed [PW-1:0]  prod;
    logic signed [PW-1:0]  scaled;
    logic signed [C_W-1:0] coord_res;
    logic [EB-1:0]         two_minus_e;
    logic [BW-1:0]         recip_den;
    logic                  accept;

    assign accept = in_valid && in_ready;

    pd_lzc_norm #(.W_W(W_W), .LZ_W(LZ_W)) u_norm (
        .w       (w_q),
        .lz      (lz_c),
        .mant    (mant_c),
        .is_zero (zero_c)
    );

    pd_seed_rom #(.IDX_W(IDX_W), .SEED_W(SEED_W)) u_rom (
        .idx  (mant_c[W_W-2 -: IDX_W]),
        .seed (seed_c)
    );

    pd_mul #(.AW(AW), .BW(BW), .PW(PW)) u_mul (
        .a (mul_a),
        .b (mul_b),
        .p (prod)
    );

    // Newton correction term and reciprocal shifted back by the normalization
    assign two_minus_e = EB'(1 << (MF + 1)) - e_q;
    assign recip_den   = BW'(r_q) << lz_q;

    // operand selection for the shared multiplier
    always_comb begin
        mul_a = '0;
        mul_b = '0;
        unique case (state_q)
            ST_EST1, ST_EST2: begin
                mul_a = AW'(m_q);
                mul_b = BW'(r_q);
            end
            ST_REF1, ST_REF2: begin
                mul_a = AW'(r_q);
                mul_b = BW'(two_minus_e);
            end
            ST_MULX: begin
                mul_a = AW'(x_q);
                mul_b = recip_den;
            end
            ST_MULY: begin
                mul_a = AW'(y_q);
                mul_b = recip_den;
            end
            ST_MULZ: begin
                mul_a = AW'(z_q);
                mul_b = recip_den;
            end
            default: begin
                mul_a = '0;
                mul_b = '0;
            end
        endcase
    end

    // scale back to coordinate format and clamp
    always_comb begin
        scaled = prod >>> SH;
        if ((&scaled[PW-1:C_W-1]) || !(|scaled[PW-1:C_W-1])) begin
            coord_res = scaled[C_W-1:0];
        end else if (scaled[PW-1]) begin
            coord_res = SAT_LO;
        end else begin
            coord_res = SAT_HI;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_NORM;
            ST_NORM: state_d = zero_c ? ST_DONE : ST_EST1;
            ST_EST1: state_d = ST_REF1;
            ST_REF1: state_d = ST_EST2;
            ST_EST2: state_d = ST_REF2;
            ST_REF2: state_d = ST_MULX;
            ST_MULX: state_d = ST_MULY;
            ST_MULY: state_d = ST_MULZ;
            ST_MULZ: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q   <= '0;
            y_q   <= '0;
            z_q   <= '0;
            w_q   <= '0;
            m_q   <= '0;
            lz_q  <= '0;
            r_q   <= '0;
            e_q   <= '0;
            err_q <= 1'b0;
            ox_q  <= '0;
            oy_q  <= '0;
            oz_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        x_q <= in_x;
                        y_q <= in_y;
                        z_q <= in_z;
                        w_q <= in_w;
                    end
                end
                ST_NORM: begin
                    err_q <= zero_c;
                    m_q   <= mant_c;
                    lz_q  <= lz_c;
                    r_q   <= RB'(seed_c) << SEED_S;
                    if (zero_c) begin
                        ox_q <= SAT_HI;
                        oy_q <= SAT_HI;
                        oz_q <= SAT_HI;
                    end
                end
                ST_EST1, ST_EST2: e_q <= prod[W_W-1 +: EB];
                ST_REF1, ST_REF2: r_q <= prod[MF +: RB];
                ST_MULX: ox_q <= coord_res;
                ST_MULY: oy_q <= coord_res;
                ST_MULZ: oz_q <= coord_res;
                default: begin
                end
            endcase
        end
    end

    assign in_ready  = (state_q == ST_IDLE);
    assign out_valid = (state_q == ST_DONE);
    assign out_err   = out_valid && err_q;
    assign out_x     = ox_q;
    assign out_y     = oy_q;
    assign out_z     = oz_q;

endmodule

// File: rtl/persp_div_chk.sv
module persp_div_chk #(
    parameter int C_W = 16,
    parameter int W_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic [W_W-1:0]        in_w,
    input logic                  out_valid,
    input logic signed [C_W-1:0] out_x,
    input logic signed [C_W-1:0] out_y,
    input logic signed [C_W-1:0] out_z,
    input logic                  out_err
);
    import pdiv_pkg::*;

    localparam int CNT_W = $clog2(PD_LAT_NZ + 2) + 1;
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
    localparam logic signed [C_W-1:0] SAT_HI = {1'b0, {(C_W-1){1'b1}}};

    logic [CNT_W-1:0] since_acc;
    logic             zero_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_acc <= '0;
            zero_seen <= 1'b0;
        end else if (in_valid && in_ready) begin
            since_acc <= CNT_W'(1);
            zero_seen <= (in_w == '0);
        end else if (since_acc != '0 && since_acc != CNT_TOP) begin
            since_acc <= since_acc + 1'b1;
        end
    end

    AST_NO_RESULT_BEFORE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (since_acc == '0) |-> !out_valid); // R1

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R2

    AST_NOT_READY_IN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R2

    AST_READY_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> in_ready); // R2

    AST_ZERO_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_x == SAT_HI && out_y == SAT_HI && out_z == SAT_HI)); // R5

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (since_acc == CNT_W'(zero_seen ? PD_LAT_ZERO : PD_LAT_NZ))); // R5 R6

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R6

    AST_ERR_MATCHES_W: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_err == zero_seen)); // R7

    AST_ERR_ONLY_IN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_valid); // R7

endmodule

bind persp_div_unit persp_div_chk #(.C_W(C_W), .W_W(W_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_w      (in_w),
    .out_valid (out_valid),
    .out_x     (out_x),
    .out_y     (out_y),
    .out_z     (out_z),
    .out_err   (out_err)
);

// File: tb/tb_persp_div_unit.sv
module tb_persp_div_unit;

    localparam int CLK_PERIOD = 10;
    localparam int C_W    = 16;
    localparam int W_W    = 16;
    localparam int W_FRAC = 8;
    localparam int LAT_NZ = 9;
    localparam int LAT_Z  = 2;
    localparam longint SMAX = 32767;
    localparam longint SMIN = -32768;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic                  in_ready;
    logic signed [C_W-1:0] in_x = '0;
    logic signed [C_W-1:0] in_y = '0;
    logic signed [C_W-1:0] in_z = '0;
    logic [W_W-1:0]        in_w = '0;
    logic                  out_valid;
    logic signed [C_W-1:0] out_x, out_y, out_z;
    logic                  out_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    persp_div_unit #(.C_W(C_W), .W_W(W_W), .W_FRAC(W_FRAC)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_x      (in_x),
        .in_y      (in_y),
        .in_z      (in_z),
        .in_w      (in_w),
        .out_valid (out_valid),
        .out_x     (out_x),
        .out_y     (out_y),
        .out_z     (out_z),
        .out_err   (out_err)
    );

    function automatic longint exact_q(longint c, longint w);
        longint q;
        q = (c * (longint'(1) << W_FRAC)) / w;
        if (q > SMAX) q = SMAX;
        if (q < SMIN) q = SMIN;
        return q;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_coord(string req, string what, longint act, longint exp);
        longint d;
        d = act - exp;
        if (d < 0) d = -d;
        check(d <= 2, req, what, act, exp);
    endtask

    // Send one vertex; optionally keep offering a different vertex while busy.
    task automatic run_vec(int x, int y, int z, int w, bit tease, string req);
        int cyc;
        bit zero;
        zero = (w == 0);
        @(negedge clk);
        check(in_ready == 1'b1, "R2", "ready before offer", longint'(in_ready), 1);
        in_valid = 1'b1;
        in_x = C_W'(x); in_y = C_W'(y); in_z = C_W'(z); in_w = W_W'(w);
        @(negedge clk);
        cyc = 1;
        if (tease) begin
            in_x = C_W'(x ^ 16'h5a5a); in_y = C_W'(~y); in_z = C_W'(z + 777); in_w = '0;
        end else begin
            in_valid = 1'b0;
        end
        while (!out_valid && cyc < 40) begin
            check(in_ready == 1'b0, "R2", "ready low while busy", longint'(in_ready), 0);
            @(negedge clk);
            cyc++;
        end
        in_valid = 1'b0;
        check(cyc == (zero ? LAT_Z : LAT_NZ), zero ? "R5" : "R6", "latency", cyc,
              zero ? LAT_Z : LAT_NZ);
        check(out_err == zero, "R7", "error flag", longint'(out_err), longint'(zero));
        if (zero) begin
            check(out_x == SMAX && out_y == SMAX && out_z == SMAX, "R5", "zero-w saturation",
                  longint'(out_x), SMAX);
        end else begin
            check_coord(req, "x", longint'(out_x), exact_q(longint'(signed'(C_W'(x))), longint'(w)));
            check_coord(req, "y", longint'(out_y), exact_q(longint'(signed'(C_W'(y))), longint'(w)));
            check_coord(req, "z", longint'(out_z), exact_q(longint'(signed'(C_W'(z))), longint'(w)));
        end
        @(negedge clk);
        check(out_valid == 1'b0, "R6", "single-cycle strobe", longint'(out_valid), 0);
        check(in_ready == 1'b1, "R2", "ready after result", longint'(in_ready), 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int unused;
        unused = $urandom(32'd51966);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready in reset", longint'(in_ready), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R1", "no spontaneous result", longint'(out_valid), 0);
        check(out_err == 1'b0, "R1", "out_err after reset", longint'(out_err), 0);

        // R3: plain cases
        run_vec(256, -512, 1000, 256, 1'b0, "R3");
        run_vec(300, 77, -4000, 768, 1'b0, "R3");
        run_vec(-1, 1, 0, 65535, 1'b0, "R3");

        // R8: every power of two, smallest and largest codes
        for (int k = 0; k < W_W; k++) begin
            run_vec(1234, -2345, 89, 1 << k, 1'b0, "R8");
        end
        run_vec(5, -3, 1, 1, 1'b0, "R8");
        run_vec(32767, -32768, 12345, 65535, 1'b0, "R8");
        run_vec(20000, -20000, 100, 32767, 1'b0, "R8");
        run_vec(20000, -20000, 100, 3, 1'b0, "R8");

        // R4: clamp both directions
        run_vec(32767, -32768, 256, 1, 1'b0, "R4");
        run_vec(1000, -1000, 0, 2, 1'b0, "R4");

        // R5: zero w, and R2 offers while busy
        run_vec(100, 200, 300, 0, 1'b0, "R5");
        run_vec(400, -500, 600, 1000, 1'b1, "R2");
        run_vec(-7, 8, -9, 0, 1'b1, "R5");

        // R3: constrained random sweep of w with random coordinates
        for (int n = 0; n < 400; n++) begin
            int rw;
            int sel;
            sel = int'($urandom_range(0, 3));
            if (sel == 0) rw = int'($urandom_range(1, 255));
            else if (sel == 1) rw = int'($urandom_range(256, 4095));
            else rw = int'($urandom_range(1, 65535));
            run_vec(int'($urandom_range(0, 65535)) - 32768,
                    int'($urandom_range(0, 65535)) - 32768,
                    int'($urandom_range(0, 2047)) - 1024,
                    rw, (n % 7) == 0, "R3");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule